// File: doc/BRIEF.md
# Serial Signed-Digit Adder with Operand Framing

This block adds two radix-2 signed-digit numbers that arrive one digit per clock, most significant digit first. Each digit is carried on a pair of wires: a positive bit and a negative bit. The digit's value is the positive bit minus the negative bit. The adder core has no carry chain. It is two layers of a single redundant full-adder cell laid out along time instead of space, so the result also leaves most significant digit first, two clocks behind the operands. Because every output digit is produced while later operand digits are still arriving, the adder can be chained with other digit-serial operators without waiting for whole words.

An operand-valid line travels alongside the digits and marks each operand frame. A framing controller delays that line by the adder delay to produce the result-valid line. It tracks each frame through four states:

- `FR_IDLE`: nothing is in flight.
- `FR_ACTIVE`: operand digits are entering.
- `FR_FLUSH`: the last result digits are draining.
- `FR_CLEAR`: the pipe is empty.

The transitions between them are:

- START: `FR_IDLE`→`FR_ACTIVE`.
- END: `FR_ACTIVE`→`FR_FLUSH` when the valid line drops.
- RESUME: `FR_FLUSH`→`FR_ACTIVE`.
- DRAINED: `FR_FLUSH`→`FR_CLEAR`.
- REOPEN: `FR_CLEAR`→`FR_ACTIVE`.
- SETTLE: `FR_CLEAR`→`FR_IDLE`.

The core's three state registers are wiped only in `FR_CLEAR` or `FR_IDLE` while no operand is present. An output switch drives a zero digit whenever the result-valid line is low. Digits presented while the operand-valid line is low are treated as zero.

Top module: `sd_serial_adder`

## Requirements
- R1: A frame is a run of F ≥ 2 consecutive cycles with `op_valid` high. Digit k of the frame, for k = 0..F-1, has weight 2^(F-1-k). If the first digit of both operands is encoded (0,0), the F result digits, read with the same weights, sum to exactly A + B.
- R2: `sum_valid` in any cycle equals `op_valid` two cycles earlier (counting only cycles after reset). Result digit k is therefore visible exactly two clocks after operand digit k.
- R3: While `sum_valid` is low, `s_pos` and `s_neg` are both 0.
- R4: Operand digit bits presented while `op_valid` is low have no effect on any later result digit.
- R5: The core state registers are cleared by the framing controller whenever the pipe is empty. Consecutive frames separated by three or more low cycles of `op_valid` are each summed correctly, whatever the previous frame left in the core.
- R6: Encoding: (pos,neg) = (1,0) is +1, (0,1) is −1, and both (0,0) and (1,1) are 0. The two zero encodings give identical sums.
- R7: A synchronous active-high `rst` clears the delayed valid bits, the framing state and the core registers. After reset `sum_valid` is 0 and the output digit is (0,0). A frame cut off by reset produces no output, and the next frame is summed correctly.
- R8: The core clear is never asserted in a cycle where `op_valid` or `sum_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | High while operand digits are present |
| a_pos | input | 1 | Operand A digit, positive bit |
| a_neg | input | 1 | Operand A digit, negative bit |
| b_pos | input | 1 | Operand B digit, positive bit |
| b_neg | input | 1 | Operand B digit, negative bit |
| sum_valid | output | 1 | `op_valid` delayed by two clocks |
| s_pos | output | 1 | Result digit, positive bit |
| s_neg | output | 1 | Result digit, negative bit |

## Verification
The assertions check these properties on every cycle:

- the two-cycle relation between `sum_valid` and `op_valid`;
- the zero output outside a result frame;
- the core registers reading zero after a clear or a reset;
- that a clear never overlaps live operand or result digits.

Whether the digits inside a frame really add up to A + B, and whether garbage driven between frames stays out of the result, can only be shown by the bench. It folds each result frame into an integer and compares it with the sum of the operands it sent. It does this for random digits and gaps, for all-positive, all-negative, cancelling and redundant-zero operands, for minimum-length frames, for minimum gaps and after a reset that cuts off a frame.

// File: rtl/sd_serial_pkg.sv
package sd_serial_pkg;

    // One signed digit: value = pos - neg
    typedef struct packed {
        logic pos;
        logic neg;
    } sd_digit_t;

    // Framing controller phases
    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_ACTIVE = 2'd1,
        FR_FLUSH  = 2'd2,
        FR_CLEAR  = 2'd3
    } frame_state_e;

    // On-line delay of the two-layer carry-free adder, in digits
    localparam int unsigned SD_ADD_DELAY = 2;

endpackage

// File: rtl/sd_fa_cell.sv
// Redundant full-adder cell. Two inputs of one sign (x, y) and one of the
// opposite sign (z): x + y - z = 2*hi - lo. Used as the plus-plus-minus
// cell with positive x,y, and as the minus-minus-plus cell with negative x,y
// (where the identity reads z - x - y = lo - 2*hi).
module sd_fa_cell (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic hi,
    output logic lo
);
    always_comb begin
        hi = (x & y) | (x & ~z) | (y & ~z);
        lo = x ^ y ^ z;
    end
endmodule

// File: rtl/sd_digit_core.sv
// Digit-serial carry-free signed-digit adder, most significant digit first.
// With operand digit of rank k entering, it emits result digit of rank k-2.
module sd_digit_core
    import sd_serial_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  sd_digit_t a_dig,
    input  sd_digit_t b_dig,
    output sd_digit_t s_dig,
    output logic [2:0] state_q
);
    // first layer (plus-plus-minus): weight-2 positive carry, same-rank negative bit
    logic l1_hi;
    logic l1_lo;
    // second layer (minus-minus-plus): weight-2 negative carry, same-rank positive bit
    logic l2_hi;
    logic l2_lo;

    // registered state: one rank behind the input
    logic l1_lo_q;   // negative bit of layer 1 for previous rank
    logic b_neg_q;   // negative bit of operand B for previous rank
    logic l2_lo_q;   // positive bit of layer 2, two ranks behind

    sd_fa_cell u_ppm (
        .x  (a_dig.pos),
        .y  (b_dig.pos),
        .z  (a_dig.neg),
        .hi (l1_hi),
        .lo (l1_lo)
    );

    sd_fa_cell u_mmp (
        .x  (l1_lo_q),
        .y  (b_neg_q),
        .z  (l1_hi),
        .hi (l2_hi),
        .lo (l2_lo)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            l1_lo_q <= 1'b0;
            b_neg_q <= 1'b0;
            l2_lo_q <= 1'b0;
        end else begin
            l1_lo_q <= l1_lo;
            b_neg_q <= b_dig.neg;
            l2_lo_q <= l2_lo;
        end
    end

    always_comb begin
        s_dig.pos = l2_lo_q;
        s_dig.neg = l2_hi;
        state_q   = {l2_lo_q, b_neg_q, l1_lo_q};
    end
endmodule

// File: rtl/sd_frame_ctrl.sv
// Framing controller: delays the valid line by DEPTH cycles and decides
// when the adder core may be cleared.
module sd_frame_ctrl
    import sd_serial_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout,
    output logic core_clr
);
    localparam int unsigned CW       = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int unsigned FLUSH_LAST = (DEPTH > 2) ? (DEPTH - 2) : 0;

    logic [DEPTH-1:0] vshift;
    frame_state_e     state;
    frame_state_e     state_nx;
    logic [CW-1:0]    flush_cnt;
    logic             flush_done;

    // delay line for the valid bit
    always_ff @(posedge clk) begin
        if (rst) vshift[0] <= 1'b0;
        else     vshift[0] <= vin;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_vdelay
        always_ff @(posedge clk) begin
            if (rst) vshift[g] <= 1'b0;
            else     vshift[g] <= vshift[g-1];
        end
    end

    // counts cycles spent draining
    always_ff @(posedge clk) begin
        if (rst || state != FR_FLUSH) flush_cnt <= '0;
        else                          flush_cnt <= flush_cnt + 1'b1;
    end

    assign flush_done = (flush_cnt == CW'(FLUSH_LAST));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= FR_IDLE;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE:   if (vin) state_nx = FR_ACTIVE;            // START
            FR_ACTIVE: if (!vin) state_nx = FR_FLUSH;            // END
            FR_FLUSH: begin
                if (vin)             state_nx = FR_ACTIVE;       // RESUME
                else if (flush_done) state_nx = FR_CLEAR;        // DRAINED
            end
            FR_CLEAR: begin
                if (vin) state_nx = FR_ACTIVE;                   // REOPEN
                else     state_nx = FR_IDLE;                     // SETTLE
            end
            default:   state_nx = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        vout     = vshift[DEPTH-1];
        core_clr = 1'b0;
        unique case (state)
            FR_IDLE, FR_CLEAR: core_clr = !vin;
            FR_ACTIVE, FR_FLUSH: core_clr = 1'b0;
            default:   core_clr = 1'b0;
        endcase
    end
endmodule

// File: rtl/sd_serial_adder.sv
module sd_serial_adder
    import sd_serial_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_valid,
    input  logic a_pos,
    input  logic a_neg,
    input  logic b_pos,
    input  logic b_neg,
    output logic sum_valid,
    output logic s_pos,
    output logic s_neg
);
    localparam int unsigned ADD_DELAY = SD_ADD_DELAY;

    sd_digit_t  a_gated;
    sd_digit_t  b_gated;
    sd_digit_t  raw_sum;
    logic       frm_clr;
    logic [2:0] core_q;

    // digits outside a frame are read as zero
    always_comb begin
        a_gated = op_valid ? sd_digit_t'{pos: a_pos, neg: a_neg} : '0;
        b_gated = op_valid ? sd_digit_t'{pos: b_pos, neg: b_neg} : '0;
    end

    sd_frame_ctrl #(
        .DEPTH (ADD_DELAY)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .vin      (op_valid),
        .vout     (sum_valid),
        .core_clr (frm_clr)
    );

    sd_digit_core u_core (
        .clk     (clk),
        .rst     (rst),
        .clr     (frm_clr),
        .a_dig   (a_gated),
        .b_dig   (b_gated),
        .s_dig   (raw_sum),
        .state_q (core_q)
    );

    // output switch
    always_comb begin
        s_pos = sum_valid & raw_sum.pos;
        s_neg = sum_valid & raw_sum.neg;
    end
endmodule

// File: rtl/sd_serial_adder_chk.sv
module sd_serial_adder_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic       sum_valid,
    input logic       s_pos,
    input logic       s_neg,
    input logic       clr,
    input logic [2:0] core_q
);
    // cycles since reset, saturating
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (sum_valid == $past(op_valid, 2)));

    a_r3_quiet_zero: assert property (@(posedge clk) disable iff (rst)
        !sum_valid |-> (!s_pos && !s_neg));

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (core_q == 3'b000));

    a_r8_clear_when_quiet: assert property (@(posedge clk) disable iff (rst)
        clr |-> (!op_valid && !sum_valid));

    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (!sum_valid && core_q == 3'b000));
endmodule

bind sd_serial_adder sd_serial_adder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .sum_valid (sum_valid),
    .s_pos     (s_pos),
    .s_neg     (s_neg),
    .clr       (frm_clr),
    .core_q    (core_q)
);

// File: tb/sd_serial_adder_test.sv
module sd_serial_adder_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_F      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic a_pos = 1'b0, a_neg = 1'b0, b_pos = 1'b0, b_neg = 1'b0;
    logic sum_valid, s_pos, s_neg;

    int n_checks = 0;
    int n_errors = 0;
    int dly_bad = 0;
    int quiet_bad = 0;
    int unsigned seed_init;

    longint exp_q[$];
    int     len_q[$];
    string  tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_serial_adder uut (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .a_pos     (a_pos),
        .a_neg     (a_neg),
        .b_pos     (b_pos),
        .b_neg     (b_neg),
        .sum_valid (sum_valid),
        .s_pos     (s_pos),
        .s_neg     (s_neg)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint dval(input logic p, input logic m);
        return longint'(p) - longint'(m);
    endfunction

    // mode: 0 random, 1 all +1, 2 all -1, 3 redundant zeros (1,1), 4 A=+1s B=-1s
    task automatic send_frame(input int f, input int mode, input int gap, input string tag);
        logic [MAX_F-1:0] ap, am, bp, bm;
        longint ea, eb;
        ea = 0; eb = 0;
        for (int i = 0; i < f; i++) begin
            int unsigned r;
            r = $urandom;
            case (mode)
                1: begin ap[i] = 1'b1; am[i] = 1'b0; bp[i] = 1'b1; bm[i] = 1'b0; end
                2: begin ap[i] = 1'b0; am[i] = 1'b1; bp[i] = 1'b0; bm[i] = 1'b1; end
                3: begin ap[i] = 1'b1; am[i] = 1'b1; bp[i] = 1'b1; bm[i] = 1'b1; end
                4: begin ap[i] = 1'b1; am[i] = 1'b0; bp[i] = 1'b0; bm[i] = 1'b1; end
                default: begin ap[i] = r[0]; am[i] = r[1]; bp[i] = r[2]; bm[i] = r[3]; end
            endcase
            if (i == 0) begin ap[i] = 1'b0; am[i] = 1'b0; bp[i] = 1'b0; bm[i] = 1'b0; end
            ea = ea * 2 + dval(ap[i], am[i]);
            eb = eb * 2 + dval(bp[i], bm[i]);
        end
        exp_q.push_back(ea + eb);
        len_q.push_back(f);
        tag_q.push_back(tag);
        for (int i = 0; i < f; i++) begin
            @(negedge clk);
            op_valid = 1'b1;
            a_pos = ap[i]; a_neg = am[i]; b_pos = bp[i]; b_neg = bm[i];
        end
        for (int g = 0; g < gap; g++) begin
            int unsigned r;
            r = $urandom;
            @(negedge clk);
            op_valid = 1'b0;
            a_pos = r[0]; a_neg = r[1]; b_pos = r[2]; b_neg = r[3];   // garbage, R4
        end
    endtask

    // monitor: folds result frames into integers
    initial begin
        longint acc = 0;
        int     len = 0;
        bit     in_frame = 1'b0;
        logic   p1 = 1'b0, p2 = 1'b0;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rst) begin
                acc = 0; len = 0; in_frame = 1'b0; p1 = 1'b0; p2 = 1'b0;
            end else begin
                if (sum_valid !== p2) dly_bad++;
                if (!sum_valid && (s_pos || s_neg)) quiet_bad++;
                if (sum_valid) begin
                    acc = acc * 2 + dval(s_pos, s_neg);
                    len++;
                    in_frame = 1'b1;
                end else if (in_frame) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1 unexpected result frame", acc, 0);
                    end else begin
                        longint e;
                        int     el;
                        string  t;
                        e = exp_q.pop_front();
                        el = len_q.pop_front();
                        t = tag_q.pop_front();
                        check(acc == e, t, acc, e);
                        check(len == el, "R2 result frame length", len, el);
                    end
                    acc = 0; len = 0; in_frame = 1'b0;
                end
                p2 = p1;
                p1 = op_valid;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        seed_init = $urandom(32'h5EED_0A1D);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #(CLK_PERIOD/4);
        check(sum_valid == 1'b0, "R7 reset sum_valid", longint'(sum_valid), 0);
        check({s_pos, s_neg} == 2'b00, "R7 reset output digit", longint'({s_pos, s_neg}), 0);

        // directed corner cases
        send_frame(2, 1, 3, "R1 shortest frame");
        send_frame(8, 1, 3, "R1 all plus digits");
        send_frame(8, 2, 3, "R1 all minus digits");
        send_frame(12, 3, 4, "R6 redundant zero encoding");
        send_frame(10, 4, 5, "R1 cancelling operands");
        send_frame(16, 1, 3, "R5 back-to-back after full frame");
        send_frame(16, 2, 3, "R5 back-to-back sign flip");
        send_frame(6, 0, 3, "R5 minimum gap");
        send_frame(5, 0, 8, "R4 garbage in gap");

        // reset cutting off a frame
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            op_valid = 1'b1;
            a_pos = 1'b1; a_neg = 1'b0; b_pos = (i != 0); b_neg = 1'b0;
        end
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #(CLK_PERIOD/4);
        check(sum_valid == 1'b0, "R7 after mid-frame reset sum_valid", longint'(sum_valid), 0);
        check({s_pos, s_neg} == 2'b00, "R7 after mid-frame reset digit", longint'({s_pos, s_neg}), 0);
        send_frame(7, 0, 3, "R7 frame after mid-frame reset");

        // constrained random frames
        for (int n = 0; n < 60; n++) begin
            int f, g;
            f = 2 + int'($urandom % (MAX_F - 1));
            g = 3 + int'($urandom % 6);
            send_frame(f, 0, g, "R1 random frame");
        end

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1 frames still pending", longint'(exp_q.size()), 0);
        check(dly_bad == 0, "R2 valid delay mismatches", longint'(dly_bad), 0);
        check(quiet_bad == 0, "R3 nonzero digits outside frame", longint'(quiet_bad), 0);
        summary();
        $finish;
    end
endmodule